// File: doc/BRIEF.md
# Multi-mode sample-stream trigger detector

The block watches a stream of signed samples, one per clock, each qualified by a valid flag. It compares every accepted sample with the previous accepted one. From that comparison it raises a trigger on the output. Three detection modes are available. The edge mode fires when the signal crosses one programmed level in the chosen direction. The window mode bounds a range with two thresholds and fires when the signal enters the range or when it leaves it. The high-rate mode fires on only every fourth rising crossing of the level.

All settings are static inputs driven from configuration registers elsewhere in the chip. The single level is limited to a band around mid-scale: a request outside the band is clamped, and an error flag shows the clamp. An optional stretch setting holds the trigger high for a programmed number of cycles so that short events are not lost downstream. Stretch also forces rising-edge detection. Changing the effective mode discards the stored sample and the divide count, so that a reconfiguration cannot cause a false trigger.

Top module: `trig_detect`

## Requirements
- R1: In edge mode (cfg_hr_en=0, cfg_win_en=0) with cfg_slope=1, a valid sample x fires when the previous valid sample p satisfies p < L and x >= L, where L is the effective level. trig_out is high in the clock cycle after the edge that accepted x. Without stretch the pulse lasts one cycle.
- R2: In edge mode with cfg_slope=0 and cfg_stretch=0, a trigger fires when p >= L and x < L. A rising crossing does not fire.
- R3: Samples with smp_valid=0 never fire and do not replace the stored previous sample. The first valid sample after reset or after a mode change never fires.
- R4: In window mode (cfg_hr_en=0, cfg_win_en=1) a sample is inside when cfg_lo <= x <= cfg_hi. With cfg_win_exit=0, a trigger fires when p is outside and x is inside. With cfg_win_exit=1, a trigger fires when p is inside and x is outside. A jump from one side of the range to the other side fires in neither case.
- R5: In high-rate mode (cfg_hr_en=1) rising crossings of L are counted. Every fourth crossing fires and starts a new count, whatever the value of cfg_slope.
- R6: When cfg_hr_en=1, cfg_win_en has no effect, and high-rate behaviour applies.
- R7: When cfg_stretch=1, edge detection is rising, whatever the value of cfg_slope.
- R8: When cfg_stretch=1, a trigger holds trig_out high for cfg_hold cycles (a value of 0 gives 1 cycle). Crossings that occur while the output is held are ignored.
- R9: The effective level L is cfg_level clamped to the range -LIM to +LIM, with LIM = floor(0.6 * 2^(DW-1)), which is 76 for DW=8. level_err is combinationally high exactly while cfg_level lies outside that range.
- R10: A change of the effective mode (edge, window or high-rate) clears the stored sample and the high-rate count. A sample from before the change cannot form a crossing with a sample after the change.
- R11: While reset is applied, and after reset, trig_out is 0, no previous sample is held, and the high-rate count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | Sample qualifier |
| smp_data | input | DW | Signed sample |
| cfg_hr_en | input | 1 | High-rate divide-by-four mode select |
| cfg_win_en | input | 1 | Window mode select (ignored when cfg_hr_en=1) |
| cfg_slope | input | 1 | Edge direction: 1 rising, 0 falling |
| cfg_win_exit | input | 1 | Window: 1 fire on leaving, 0 fire on entering |
| cfg_level | input | DW | Signed requested level |
| cfg_lo | input | DW | Signed lower window threshold |
| cfg_hi | input | DW | Signed upper window threshold |
| cfg_stretch | input | 1 | Stretch enable, forces rising slope |
| cfg_hold | input | HW | Stretch hold length in cycles |
| trig_out | output | 1 | Trigger output |
| level_err | output | 1 | Requested level out of band, clamped |

## Verification
The bench builds the block with its defaults: DW=8, HW=4 and a divide ratio of 4. At these values the clamp limit of 76 lies inside the 8-bit code range, so the bench can request levels on both sides of it. A four-bit hold allows a hold of five cycles, long enough to place a full crossing inside the hold. The divide ratio of 4 lets the bench check both the rollover of the count and a repeated cycle of four crossings with a few samples. Samples that equal a threshold, invalid gaps, slope override by stretch, window requests during high-rate mode, and mode changes that discard a stored sample are each driven as directed cases.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [1:0] {
    MODE_EDGE = 2'd0,
    MODE_WIN  = 2'd1,
    MODE_HR   = 2'd2
  } trig_mode_e;
endpackage

// File: rtl/trig_level_clamp.sv
module trig_level_clamp #(
  parameter int DW = 8
) (
  input  logic signed [DW-1:0] req_level,
  output logic signed [DW-1:0] eff_level,
  output logic                 out_of_band
);
  localparam int LIM = ((2 ** (DW - 1)) * 6) / 10;
  localparam logic signed [DW-1:0] POS_LIM = DW'(LIM);
  localparam logic signed [DW-1:0] NEG_LIM = -POS_LIM;

  logic too_high;
  logic too_low;

  always_comb begin
    too_high = req_level > POS_LIM;
    too_low  = req_level < NEG_LIM;
    out_of_band = too_high | too_low;
    if (too_high)     eff_level = POS_LIM;
    else if (too_low) eff_level = NEG_LIM;
    else              eff_level = req_level;
  end
endmodule

// File: rtl/trig_cross_det.sv
module trig_cross_det #(
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 valid,
  input  logic signed [DW-1:0] data,
  input  logic signed [DW-1:0] level,
  input  logic signed [DW-1:0] lo,
  input  logic signed [DW-1:0] hi,
  output logic                 rise,
  output logic                 fall,
  output logic                 enter,
  output logic                 leave,
  output logic                 have_prev
);
  logic signed [DW-1:0] prev_q, prev_d;
  logic                 ok_q, ok_d;
  logic                 cmp_ok;
  logic                 prev_ge, cur_ge;
  logic                 prev_in, cur_in;

  always_comb begin
    prev_d = prev_q;
    ok_d   = ok_q;
    if (clr) begin
      ok_d = 1'b0;
    end else if (valid) begin
      prev_d = data;
      ok_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      ok_q   <= 1'b0;
    end else begin
      prev_q <= prev_d;
      ok_q   <= ok_d;
    end
  end

  always_comb begin
    cmp_ok  = valid & ok_q;
    prev_ge = prev_q >= level;
    cur_ge  = data >= level;
    prev_in = (prev_q >= lo) && (prev_q <= hi);
    cur_in  = (data >= lo) && (data <= hi);
    rise    = cmp_ok & ~prev_ge & cur_ge;
    fall    = cmp_ok & prev_ge & ~cur_ge;
    enter   = cmp_ok & ~prev_in & cur_in;
    leave   = cmp_ok & prev_in & ~cur_in;
  end

  assign have_prev = ok_q;
endmodule

// File: rtl/trig_prescale.sv
module trig_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic evt,
  output logic fire
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    fire  = evt && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (fire) cnt_d = '0;
    else if (evt)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/trig_pulse_hold.sv
module trig_pulse_hold #(
  parameter int HW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [HW-1:0] len,
  output logic          busy
);
  logic [HW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (fire) begin
      cnt_d = (len == '0) ? HW'(1) : len;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = cnt_q != '0;
endmodule

// File: rtl/trig_detect.sv
module trig_detect
  import trig_pkg::*;
#(
  parameter int DW  = 8,
  parameter int HW  = 4,
  parameter int DIV = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic signed [DW-1:0] smp_data,
  input  logic                 cfg_hr_en,
  input  logic                 cfg_win_en,
  input  logic                 cfg_slope,
  input  logic                 cfg_win_exit,
  input  logic signed [DW-1:0] cfg_level,
  input  logic signed [DW-1:0] cfg_lo,
  input  logic signed [DW-1:0] cfg_hi,
  input  logic                 cfg_stretch,
  input  logic [HW-1:0]        cfg_hold,
  output logic                 trig_out,
  output logic                 level_err
);
  logic [1:0]           rst_sync_q;
  logic                 rst_i_n;
  trig_mode_e           mode_d, mode_q;
  logic                 mode_chg;
  logic signed [DW-1:0] lvl_eff;
  logic                 rise_raw, fall_raw, enter_raw, leave_raw, prev_ok;
  logic                 busy;
  logic                 gate;
  logic                 edge_evt, win_evt, hr_evt, hr_fire;
  logic                 fire;
  logic [HW-1:0]        hold_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  always_comb begin
    if (cfg_hr_en)       mode_d = MODE_HR;
    else if (cfg_win_en) mode_d = MODE_WIN;
    else                 mode_d = MODE_EDGE;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) mode_q <= MODE_EDGE;
    else          mode_q <= mode_d;
  end
  assign mode_chg = mode_d != mode_q;

  trig_level_clamp #(.DW(DW)) u_clamp (
    .req_level   (cfg_level),
    .eff_level   (lvl_eff),
    .out_of_band (level_err)
  );

  trig_cross_det #(.DW(DW)) u_cross (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .clr       (mode_chg),
    .valid     (smp_valid),
    .data      (smp_data),
    .level     (lvl_eff),
    .lo        (cfg_lo),
    .hi        (cfg_hi),
    .rise      (rise_raw),
    .fall      (fall_raw),
    .enter     (enter_raw),
    .leave     (leave_raw),
    .have_prev (prev_ok)
  );

  always_comb begin
    gate     = ~(cfg_stretch & busy) & ~mode_chg;
    edge_evt = (cfg_slope | cfg_stretch) ? rise_raw : fall_raw;
    win_evt  = cfg_win_exit ? leave_raw : enter_raw;
    hr_evt   = rise_raw & gate & (mode_d == MODE_HR);
  end

  trig_prescale #(.DIV(DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (mode_chg),
    .evt   (hr_evt),
    .fire  (hr_fire)
  );

  always_comb begin
    unique case (mode_d)
      MODE_WIN: fire = win_evt & gate;
      MODE_HR:  fire = hr_fire;
      default:  fire = edge_evt & gate;
    endcase
    hold_len = cfg_stretch ? cfg_hold : HW'(1);
  end

  trig_pulse_hold #(.HW(HW)) u_hold (
    .clk   (clk),
    .rst_n (rst_i_n),
    .fire  (fire),
    .len   (hold_len),
    .busy  (busy)
  );

  assign trig_out = busy;
endmodule

// File: rtl/trig_detect_chk.sv
module trig_detect_chk #(
  parameter int DW = 8,
  parameter int HW = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_valid,
  input logic signed [DW-1:0] cfg_level,
  input logic signed [DW-1:0] lvl_eff,
  input logic                 level_err,
  input logic                 fire,
  input logic                 rise_raw,
  input logic                 hr_sel,
  input logic                 mode_chg,
  input logic                 prev_ok,
  input logic                 busy,
  input logic                 cfg_stretch,
  input logic [HW-1:0]        cfg_hold,
  input logic                 trig_out
);
  localparam int LIM = ((2 ** (DW - 1)) * 6) / 10;
  localparam logic signed [DW-1:0] POS_LIM = DW'(LIM);

  always_comb begin
    if (!level_err)
      AST_LEVEL_PASS: assert (lvl_eff == cfg_level); // R9
    else
      AST_LEVEL_CLAMP: assert (lvl_eff == POS_LIM || lvl_eff == -POS_LIM); // R9
  end

  AST_NO_FIRE_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> !fire); // R3

  AST_HR_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_sel && fire) |-> rise_raw); // R5

  AST_MODE_CLEARS_PREV: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !prev_ok); // R10

  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_stretch && busy) |-> !fire); // R8

  AST_HOLD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_stretch && $rose(trig_out) && cfg_hold > HW'(1) && $stable(cfg_hold)) |=> trig_out); // R8
endmodule

bind trig_detect trig_detect_chk #(.DW(DW), .HW(HW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .smp_valid   (smp_valid),
  .cfg_level   (cfg_level),
  .lvl_eff     (lvl_eff),
  .level_err   (level_err),
  .fire        (fire),
  .rise_raw    (rise_raw),
  .hr_sel      (cfg_hr_en),
  .mode_chg    (mode_chg),
  .prev_ok     (prev_ok),
  .busy        (busy),
  .cfg_stretch (cfg_stretch),
  .cfg_hold    (cfg_hold),
  .trig_out    (trig_out)
);

// File: tb/sim_trig_detect.sv
module sim_trig_detect;
  localparam int PER = 10;
  localparam int NV  = 12;
  // {valid, data[7:0], expected trig}; edge mode, rising, level 10
  localparam logic [9:0] VEC [NV] = '{
    {1'b1, 8'd0,   1'b0},
    {1'b1, 8'd20,  1'b1},
    {1'b1, 8'd30,  1'b0},
    {1'b1, 8'd5,   1'b0},
    {1'b0, 8'd50,  1'b0},
    {1'b1, 8'd10,  1'b1},
    {1'b1, 8'd9,   1'b0},
    {1'b0, 8'd20,  1'b0},
    {1'b1, 8'd9,   1'b0},
    {1'b1, 8'd11,  1'b1},
    {1'b1, 8'h9C,  1'b0},
    {1'b1, 8'd127, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic smp_valid;
  logic signed [7:0] smp_data;
  logic cfg_hr_en, cfg_win_en, cfg_slope, cfg_win_exit, cfg_stretch;
  logic signed [7:0] cfg_level, cfg_lo, cfg_hi;
  logic [3:0] cfg_hold;
  logic trig_out, level_err;
  int n_run = 0;
  int n_fail = 0;

  always #(PER/2) clk = ~clk;

  trig_detect u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .cfg_hr_en(cfg_hr_en), .cfg_win_en(cfg_win_en), .cfg_slope(cfg_slope),
    .cfg_win_exit(cfg_win_exit), .cfg_level(cfg_level), .cfg_lo(cfg_lo),
    .cfg_hi(cfg_hi), .cfg_stretch(cfg_stretch), .cfg_hold(cfg_hold),
    .trig_out(trig_out), .level_err(level_err)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic signed [7:0] d,
                      input logic exp, input string tag);
    @(negedge clk);
    smp_valid = v;
    smp_data  = d;
    @(posedge clk);
    #1;
    check(trig_out, exp, tag);
  endtask

  task automatic idle(input logic exp, input string tag);
    step(1'b0, 8'sd0, exp, tag);
  endtask

  initial begin
    #(PER * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0;
    cfg_hr_en = 1'b0; cfg_win_en = 1'b0; cfg_slope = 1'b1; cfg_win_exit = 1'b0;
    cfg_level = 8'sd10; cfg_lo = -8'sd10; cfg_hi = 8'sd10;
    cfg_stretch = 1'b0; cfg_hold = 4'd1;
    repeat (3) @(posedge clk);
    #1;
    check(trig_out, 1'b0, "R11 trig low in reset");
    @(negedge clk);
    rst_n = 1'b1;
    idle(1'b0, "R11 after reset");
    idle(1'b0, "R11 after reset");
    idle(1'b0, "R11 after reset");

    // R1 / R3 table walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][9], VEC[i][8:1], VEC[i][0], "R1 table");
    end

    // R2 falling edge
    cfg_slope = 1'b0;
    step(1'b1, 8'sd20, 1'b0, "R2 setup");
    step(1'b1, 8'sd5,  1'b1, "R2 falling fires");
    step(1'b1, 8'sd20, 1'b0, "R2 rising ignored");
    step(1'b1, 8'sd10, 1'b0, "R2 equal is at-or-above");

    // R4 window, enter
    cfg_slope = 1'b1; cfg_win_en = 1'b1;
    idle(1'b0, "R10 mode change");
    step(1'b1, 8'sd50,  1'b0, "R4 first sample");
    step(1'b1, 8'sd10,  1'b1, "R4 enter at hi");
    step(1'b1, 8'sd0,   1'b0, "R4 stay inside");
    step(1'b1, 8'sd11,  1'b0, "R4 exit ignored in enter");
    step(1'b1, -8'sd11, 1'b0, "R4 jump across");
    step(1'b1, -8'sd10, 1'b1, "R4 enter at lo");
    cfg_win_exit = 1'b1;
    step(1'b1, -8'sd11, 1'b1, "R4 leave fires");
    step(1'b1, 8'sd0,   1'b0, "R4 enter ignored in exit");
    step(1'b1, 8'sd50,  1'b1, "R4 leave above");
    cfg_win_exit = 1'b0;

    // R5 / R6 high-rate with window also requested
    cfg_hr_en = 1'b1; cfg_level = 8'sd0; cfg_lo = 8'sd5; cfg_hi = 8'sd20; cfg_slope = 1'b0;
    idle(1'b0, "R10 mode change");
    for (int k = 0; k < 8; k++) begin
      step(1'b1, -8'sd10, 1'b0, "R6 window ignored");
      step(1'b1, 8'sd10, (k % 4) == 3, "R5 every fourth rise");
    end

    // R10 mode change discards stored sample
    cfg_hr_en = 1'b0; cfg_win_en = 1'b0; cfg_slope = 1'b1; cfg_level = 8'sd10;
    idle(1'b0, "R10 mode change");
    step(1'b1, 8'sd0, 1'b0, "R10 setup");
    @(negedge clk); smp_valid = 1'b0; cfg_win_en = 1'b1;
    @(negedge clk); cfg_win_en = 1'b0;
    step(1'b1, 8'sd20, 1'b0, "R10 no crossing across change");
    step(1'b1, 8'sd0,  1'b0, "R10 resume");
    step(1'b1, 8'sd20, 1'b1, "R10 crossing after change");

    // R9 clamp
    cfg_level = 8'sd100; #1;
    check(level_err, 1'b1, "R9 err high positive");
    cfg_level = -8'sd100; #1;
    check(level_err, 1'b1, "R9 err high negative");
    cfg_level = 8'sd77; #1;
    check(level_err, 1'b1, "R9 err at 77");
    cfg_level = 8'sd76; #1;
    check(level_err, 1'b0, "R9 no err at 76");
    cfg_level = 8'sd100;
    step(1'b1, 8'sd70, 1'b0, "R9 setup");
    step(1'b1, 8'sd80, 1'b1, "R9 clamped level fires");
    cfg_level = -8'sd100;
    step(1'b1, -8'sd80, 1'b0, "R9 setup negative");
    step(1'b1, -8'sd76, 1'b1, "R9 clamped negative fires");

    // R7 / R8 stretch
    cfg_level = 8'sd0; cfg_slope = 1'b0; cfg_stretch = 1'b1; cfg_hold = 4'd5;
    step(1'b1, -8'sd10, 1'b0, "R7 setup");
    step(1'b1, 8'sd10,  1'b1, "R7 rising fires with slope 0");
    step(1'b1, -8'sd10, 1'b1, "R8 hold 2");
    step(1'b1, 8'sd10,  1'b1, "R8 hold 3 crossing ignored");
    idle(1'b1, "R8 hold 4");
    idle(1'b1, "R8 hold 5");
    idle(1'b0, "R8 hold ends no retrigger");
    step(1'b1, 8'sd20,  1'b0, "R8 no crossing");
    step(1'b1, -8'sd10, 1'b0, "R7 falling ignored");
    cfg_hold = 4'd0;
    step(1'b1, 8'sd10,  1'b1, "R8 zero hold fires");
    idle(1'b0, "R8 zero hold one cycle");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule